// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This block sits beside a timekeeping core that keeps BCD time counters. It holds six alarm target registers: second, minute, hour, day of week, day of month and month. Each register has an enable bit and a BCD target value. On every clock the block compares each enabled target with the matching counter value. When all enabled targets agree with their counters, it latches an alarm flag. The flag can drive an interrupt output, which a separate enable bit gates.

Software reaches the targets and a status register through a simple port. Writes take effect on the clock edge. Reads are combinational from the address. The unit does not own the counters, rollover or the prescaler; the counter values come in on a single packed input.

A power-on reset clears only the enable bits of the targets, along with the flag and the interrupt enable. The stored target digits keep their values through reset. Software is expected to load meaningful targets before it sets any enable bit.

Top module: `rtc_alarm_match`

## Requirements
- R1: Addresses 0 to 5 select the second, minute, hour, weekday, day and month targets. A write with `bus_wr` high stores all 8 bits at the clock edge, and a read at the same address returns them.
- R2: Bit 7 of each target is its enable bit. Reset clears it to 0. Reset leaves bits 6 to 0 of every target unchanged.
- R3: Each target compares only the bits that its BCD value uses: bits 6:0 for second and minute, 5:0 for hour and day, 2:0 for weekday, and 4:0 for month. Bit 7 of each counter byte and the unused target bits are ignored. Counter field k sits at `time_cnt[8k+7:8k]`.
- R4: The combined match is the AND over the enabled targets only. A disabled target that differs from its counter does not block the match.
- R5: While no enable bit is set, the alarm flag is never set.
- R6: The flag sets one clock after the combined match goes from false to true. A match that lasts over several cycles sets the flag only once, so clearing the flag during a long match keeps it clear.
- R7: Writing status (address 6) with bit 0 = 0 clears the flag. Writing bit 0 = 1 leaves the flag as it was. If a new match edge arrives in the same cycle as a clear, the flag is set.
- R8: `irq` is high exactly when the flag and the interrupt enable (status bit 1, written from `bus_wdata[1]`) are both 1.
- R9: A status read returns the flag in bit 0, the interrupt enable in bit 1 and zeros elsewhere. Reset clears both the flag and the interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address (0-5 targets, 6 status) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| time_cnt | input | 48 | Packed BCD counters, field k at bits 8k+7:8k |
| irq | output | 1 | Alarm interrupt request |

## Verification
The bench resets with the targets already loaded. A design that reset the whole byte would lose the stored digits; one that did not reset bit 7 would start with enabled targets. It sets stray bits above the BCD width in both the counters and the targets, which catches a compare that is not masked. It also leaves a disabled target that does not match, which exposes an AND taken over all six fields.

It holds a match across a flag clear, where a level-sensitive flag would fire again. It also lines up a clear and a new match edge in the same cycle, where the wrong priority would drop an alarm. Last, it sweeps the counters with every target disabled, where a design that ignored the empty enable set would raise an alarm.

// File: rtl/rtcal_pkg.sv
package rtcal_pkg;
    localparam int NUM_FIELDS  = 6;
    localparam int DATA_W      = 8;
    localparam int ADDR_W      = 3;
    localparam int STATUS_ADDR = 6;
    localparam int ST_FLAG     = 0;
    localparam int ST_IE       = 1;

    typedef struct packed {
        logic flag;
        logic ie;
        logic seen;
    } flag_st_t;

    // Bits each BCD target uses, by field index.
    function automatic logic [DATA_W-2:0] field_mask(input int idx);
        case (idx)
            0, 1:    field_mask = 7'h7F;
            2, 4:    field_mask = 7'h3F;
            3:       field_mask = 7'h07;
            5:       field_mask = 7'h1F;
            default: field_mask = 7'h00;
        endcase
    endfunction
endpackage

// File: rtl/rtcal_field.sv
module rtcal_field #(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-2:0] MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cnt,
    output logic [DATA_W-1:0] reg_val,
    output logic              en_o,
    output logic              hit_o
);
    localparam int VAL_W = DATA_W - 1;
    localparam logic [DATA_W-1:0] FULL_MASK = {1'b0, MASK};

    logic             en_d, en_q;
    logic [VAL_W-1:0] val_d, val_q;

    always_comb begin
        en_d  = en_q;
        val_d = val_q;
        if (wr_stb) begin
            en_d  = wdata[DATA_W-1];
            val_d = wdata[VAL_W-1:0];
        end
    end

    // Enable bit is the only reset flop.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_d;
    end

    // Target digits survive reset.
    always_ff @(posedge clk) begin
        val_q <= val_d;
    end

    assign reg_val = {en_q, val_q};
    assign en_o    = en_q;
    assign hit_o   = !en_q || (({1'b0, val_q} & FULL_MASK) == (cnt & FULL_MASK));
endmodule

// File: rtl/rtcal_flag.sv
module rtcal_flag
    import rtcal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic match_all,
    input  logic st_wr,
    input  logic wd_flag,
    input  logic wd_ie,
    output logic flag_o,
    output logic ie_o,
    output logic seen_o,
    output logic irq_o
);
    flag_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.seen = match_all;
        if (st_wr) begin
            st_d.ie = wd_ie;
            if (!wd_flag) st_d.flag = 1'b0;
        end
        // A new match edge wins over a same-cycle clear.
        if (match_all && !st_q.seen) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
    assign ie_o   = st_q.ie;
    assign seen_o = st_q.seen;
    assign irq_o  = st_q.flag & st_q.ie;
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtcal_pkg::*;
#(
    parameter int N_FIELDS = NUM_FIELDS,
    parameter int DW       = DATA_W,
    parameter int AW       = ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    input  logic [N_FIELDS*DW-1:0] time_cnt,
    output logic               irq
);
    localparam int ST_ADDR = STATUS_ADDR;

    logic [N_FIELDS-1:0] en_vec;
    logic [N_FIELDS-1:0] hit_vec;
    logic [DW-1:0]       field_val [N_FIELDS];
    logic                match_all;
    logic                alarm_flag, alarm_ie, seen_q;
    logic                st_wr;

    for (genvar k = 0; k < N_FIELDS; k++) begin : g_field
        logic wr_k;
        assign wr_k = bus_wr && (bus_addr == AW'(k));
        rtcal_field #(
            .DATA_W (DW),
            .MASK   (field_mask(k))
        ) u_field (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_stb  (wr_k),
            .wdata   (bus_wdata),
            .cnt     (time_cnt[k*DW +: DW]),
            .reg_val (field_val[k]),
            .en_o    (en_vec[k]),
            .hit_o   (hit_vec[k])
        );
    end

    assign match_all = (|en_vec) && (&hit_vec);
    assign st_wr     = bus_wr && (bus_addr == AW'(ST_ADDR));

    rtcal_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .match_all (match_all),
        .st_wr     (st_wr),
        .wd_flag   (bus_wdata[ST_FLAG]),
        .wd_ie     (bus_wdata[ST_IE]),
        .flag_o    (alarm_flag),
        .ie_o      (alarm_ie),
        .seen_o    (seen_q),
        .irq_o     (irq)
    );

    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < N_FIELDS; k++) begin
            if (bus_addr == AW'(k)) bus_rdata = field_val[k];
        end
        if (bus_addr == AW'(ST_ADDR)) begin
            bus_rdata[ST_FLAG] = alarm_flag;
            bus_rdata[ST_IE]   = alarm_ie;
        end
    end
endmodule

// File: rtl/rtcal_chk.sv
module rtcal_chk
    import rtcal_pkg::*;
#(
    parameter int N_FIELDS = NUM_FIELDS,
    parameter int DW       = DATA_W,
    parameter int AW       = ADDR_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic [AW-1:0]       bus_addr,
    input logic [DW-1:0]       bus_wdata,
    input logic [DW-1:0]       bus_rdata,
    input logic                irq,
    input logic                match_all,
    input logic                seen_q,
    input logic                alarm_flag,
    input logic [N_FIELDS-1:0] en_vec
);
    logic clr_wr;
    assign clr_wr = bus_wr && (bus_addr == AW'(STATUS_ADDR)) && !bus_wdata[ST_FLAG];

    assert_reset_en_R2: assert property (@(posedge clk)
        !rst_n |=> (en_vec == '0));

    assert_no_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_vec == '0) |-> !match_all);

    assert_edge_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (match_all && !seen_q) |=> alarm_flag);

    assert_flag_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(match_all));

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !(match_all && !seen_q)) |=> !alarm_flag);

    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == AW'(STATUS_ADDR)) |-> (irq == (bus_rdata[ST_FLAG] && bus_rdata[ST_IE])));
endmodule

bind rtc_alarm_match rtcal_chk #(
    .N_FIELDS (N_FIELDS),
    .DW       (DW),
    .AW       (AW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq        (irq),
    .match_all  (match_all),
    .seen_q     (seen_q),
    .alarm_flag (alarm_flag),
    .en_vec     (en_vec)
);

// File: tb/rtc_alarm_match_tb.sv
module rtc_alarm_match_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [47:0] time_cnt = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    rtc_alarm_match u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .time_cnt  (time_cnt),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_cnt(input int idx, input logic [7:0] v);
        time_cnt[idx*8 +: 8] = v;
    endtask

    task automatic t_reset_keep;
        logic [7:0] d;
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
        rd(3'd6, d);
        check("R9 status after reset", d, 8'h00);
        check("R9 irq after reset", {7'b0, irq}, 8'h00);
        for (int k = 0; k < 6; k++) wr(3'(k), 8'h80 | 8'(k + 17));
        rst_n = 1'b0;
        tick(1);
        rst_n = 1'b1;
        tick(1);
        for (int k = 0; k < 6; k++) begin
            rd(3'(k), d);
            check("R2 enable cleared, digits kept", d, 8'(k + 17));
        end
    endtask

    task automatic t_readback;
        logic [7:0] d;
        wr(3'd2, 8'h2A);
        rd(3'd2, d);
        check("R1 hour readback", d, 8'h2A);
        wr(3'd5, 8'hD9);
        rd(3'd5, d);
        check("R1 month readback", d, 8'hD9);
    endtask

    task automatic t_and_mask;
        logic [7:0] d;
        for (int k = 0; k < 6; k++) wr(3'(k), 8'h00);
        time_cnt = '0;
        wr(3'd0, 8'hB0);
        wr(3'd1, 8'h95);
        wr(3'd3, 8'hC3);
        wr(3'd2, 8'h12);
        set_cnt(0, 8'hB0);
        set_cnt(1, 8'h14);
        set_cnt(3, 8'h03);
        set_cnt(2, 8'h07);
        tick(2);
        rd(3'd6, d);
        check("R4 partial mismatch no flag", d, 8'h00);
        set_cnt(1, 8'h15);
        tick(1);
        rd(3'd6, d);
        check("R3 R4 masked match sets flag", d, 8'h01);
    endtask

    task automatic t_persist_clear;
        logic [7:0] d;
        wr(3'd6, 8'h00);
        rd(3'd6, d);
        check("R7 clear flag", d, 8'h00);
        tick(3);
        rd(3'd6, d);
        check("R6 lasting match does not re-set", d, 8'h00);
        wr(3'd6, 8'h01);
        rd(3'd6, d);
        check("R7 write one keeps zero flag", d, 8'h00);
        set_cnt(1, 8'h14);
        tick(1);
        set_cnt(1, 8'h15);
        tick(1);
        rd(3'd6, d);
        check("R6 new edge sets flag", d, 8'h01);
        wr(3'd6, 8'h01);
        rd(3'd6, d);
        check("R7 write one keeps set flag", d, 8'h01);
    endtask

    task automatic t_collide;
        logic [7:0] d;
        set_cnt(1, 8'h14);
        tick(1);
        set_cnt(1, 8'h15);
        wr(3'd6, 8'h00);
        rd(3'd6, d);
        check("R7 set wins over clear", d, 8'h01);
    endtask

    task automatic t_irq;
        logic [7:0] d;
        check("R8 irq low with ie off", {7'b0, irq}, 8'h00);
        wr(3'd6, 8'h03);
        check("R8 irq high", {7'b0, irq}, 8'h01);
        wr(3'd6, 8'h02);
        rd(3'd6, d);
        check("R9 status ie only", d, 8'h02);
        check("R8 irq low after clear", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_none_enabled;
        logic [7:0] d;
        for (int k = 0; k < 6; k++) wr(3'(k), 8'h00);
        wr(3'd6, 8'h02);
        for (int v = 0; v < 24; v++) begin
            for (int k = 0; k < 6; k++) set_cnt(k, 8'(v));
            tick(1);
        end
        rd(3'd6, d);
        check("R5 no enable no flag", d, 8'h02);
        check("R5 irq stays low", {7'b0, irq}, 8'h00);
    endtask

    initial begin
        tick(1);
        t_reset_keep();
        t_readback();
        t_and_mask();
        t_persist_clear();
        t_collide();
        t_irq();
        t_none_enabled();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule